// File: doc/BRIEF.md
# Two-Bank Level Interrupt Controller

This block gathers 64 level-sensitive peripheral interrupt lines and 8 level-sensitive local interrupt lines. It has one enable bit per line. It drives a combined interrupt request and a separate fast interrupt request. Software changes the masks through paired set and clear registers on a plain 32-bit register port. Each set register ORs the written ones into a mask. Each clear register removes the written ones from it. Because of this, no read-modify-write is needed. Pending views are the live input levels ANDed with the masks. They are split into a low word (lines 0..31) and a high word (lines 32..63).

A summary word gives a single-read overview of the block:
- the masked local lines;
- one "anything pending" flag per 32-line peripheral bank;
- copies of eleven chosen peripheral lines.

The fast request is routed from one line, chosen by a 7-bit index. It follows that line's raw level and bypasses the masks. Both output requests are registered. A read samples the state in the cycle it is accepted and returns it on `rd_data_o` after the next clock edge.

Top module: `intc_twobank`

## Requirements
- R1: After reset, all enable masks, the fast enable and the fast select are zero, and `irq_o`, `fast_irq_o` and `rd_data_o` are low. With the masks cleared, `irq_o` stays low whatever the input levels.
- R2: A write to offset 0x10 ORs the data into mask bits 31..0. A write to 0x14 ORs it into mask bits 63..32. A write to 0x18 ORs data bits 7..0 into the local mask and ignores data bits 31..8.
- R3: A write to offset 0x1C clears every peripheral mask bit 31..0 whose data bit is 1. Offset 0x20 does the same for bits 63..32. Offset 0x24 does the same for the local mask, using data bits 7..0.
- R4: A read of 0x10, 0x14 or 0x18 returns the matching mask, with the local mask zero-extended to 32 bits. A read of 0x1C, 0x20 or 0x24 returns the 32-bit bitwise inverse of that same zero-extended value.
- R5: A read of 0x04 returns peripheral levels 31..0 ANDed with their mask bits. A read of 0x08 returns the same for lines 63..32.
- R6: A read of 0x00 returns the summary word, with all other bits zero. Its fields are:
  - bits 7..0: the masked local levels;
  - bit 8: set when any masked line 0..31 is pending;
  - bit 9: set when any masked line 32..63 is pending;
  - bits 20..10: the masked states of peripheral lines 7, 9, 10, 18, 19, 53, 54, 55, 56, 57 and 62, with line 7 in bit 10.
- R7: `irq_o` is high in the cycle after an edge at which any peripheral or local line was high with its mask bit set. Otherwise it is low.
- R8: Offset 0x0C holds the fast select in bits 6..0 and the fast enable in bit 7. A read returns those 8 bits zero-extended. `fast_irq_o`, one cycle later, equals the raw level of the selected line when the enable is set, and is low when the enable is clear. A select below 64 picks that peripheral line. A select of 64..71 picks local line (select − 64). The masks have no effect on `fast_irq_o`.
- R9: A fast select of 72..127 picks no line, and `fast_irq_o` stays low even when enabled.
- R10: An offset outside the map reads as zero and its writes change no state. This covers offsets that are not word-aligned and addresses with any bit above bit 7 set.
- R11: Read data is registered. `rd_data_o` changes only after an accepted read and holds its value through idle cycles and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Register access in this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address of the access |
| req_wdata_i | input | WORD_W | Write data |
| periph_lvl_i | input | PERIPH_N | Peripheral interrupt levels |
| local_lvl_i | input | LOCAL_N | Local interrupt levels |
| rd_data_o | output | WORD_W | Registered read data |
| irq_o | output | 1 | Combined masked interrupt request |
| fast_irq_o | output | 1 | Routed fast interrupt request |

## Verification
The bench builds the block with its default parameters:
- 32-bit words;
- 64 peripheral lines in two banks;
- 8 local lines;
- a 12-bit address.

With these defaults, both bank halves of every set, clear and pending register are exercised. So is every region of the 7-bit fast select: peripheral lines, local lines, and the unused codes 72..127. The four address bits above the register window allow checks that an access which aliases a valid offset in its low byte is still rejected. A reference model in the bench predicts every read, `irq_o` and `fast_irq_o` from the register contents before each access.

// File: rtl/intc_twobank_pkg.sv
package intc_twobank_pkg;

    // Decoded register selection
    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_SUMMARY,
        SEL_PEND_LO,
        SEL_PEND_HI,
        SEL_FAST_CTL,
        SEL_EN_LO,
        SEL_EN_HI,
        SEL_EN_LOC,
        SEL_DIS_LO,
        SEL_DIS_HI,
        SEL_DIS_LOC
    } reg_sel_e;

    localparam int unsigned MIRROR_N = 11;

    // Word-aligned byte offsets; anything else selects nothing
    function automatic reg_sel_e decode_ofs(input logic [7:0] ofs);
        case (ofs)
            8'h00:   return SEL_SUMMARY;
            8'h04:   return SEL_PEND_LO;
            8'h08:   return SEL_PEND_HI;
            8'h0C:   return SEL_FAST_CTL;
            8'h10:   return SEL_EN_LO;
            8'h14:   return SEL_EN_HI;
            8'h18:   return SEL_EN_LOC;
            8'h1C:   return SEL_DIS_LO;
            8'h20:   return SEL_DIS_HI;
            8'h24:   return SEL_DIS_LOC;
            default: return SEL_NONE;
        endcase
    endfunction

    function automatic reg_sel_e en_sel_of_bank(input int b);
        return (b == 0) ? SEL_EN_LO : SEL_EN_HI;
    endfunction

    function automatic reg_sel_e dis_sel_of_bank(input int b);
        return (b == 0) ? SEL_DIS_LO : SEL_DIS_HI;
    endfunction

    // Peripheral line copied into summary bit (10 + k)
    function automatic int unsigned mirror_src(input int unsigned k);
        case (k)
            0:       return 7;
            1:       return 9;
            2:       return 10;
            3:       return 18;
            4:       return 19;
            5:       return 53;
            6:       return 54;
            7:       return 55;
            8:       return 56;
            9:       return 57;
            default: return 62;
        endcase
    endfunction

endpackage

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs
    import intc_twobank_pkg::*;
#(
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned PERIPH_N = 64,
    parameter int unsigned LOCAL_N  = 8,
    parameter int unsigned SEL_W    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  reg_sel_e            sel,
    input  logic [WORD_W-1:0]   wdata,
    output logic [PERIPH_N-1:0] pen_mask,
    output logic [LOCAL_N-1:0]  loc_mask,
    output logic                fast_en,
    output logic [SEL_W-1:0]    fast_sel
);
    localparam int unsigned N_BANKS = PERIPH_N / WORD_W;

    typedef struct packed {
        logic [PERIPH_N-1:0] pen;
        logic [LOCAL_N-1:0]  len;
        logic                fen;
        logic [SEL_W-1:0]    fsel;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int b = 0; b < N_BANKS; b++) begin
                if (sel == en_sel_of_bank(b))
                    st_d.pen[b*WORD_W +: WORD_W] = st_q.pen[b*WORD_W +: WORD_W] | wdata;
                if (sel == dis_sel_of_bank(b))
                    st_d.pen[b*WORD_W +: WORD_W] = st_q.pen[b*WORD_W +: WORD_W] & ~wdata;
            end
            case (sel)
                SEL_EN_LOC:   st_d.len = st_q.len | wdata[LOCAL_N-1:0];
                SEL_DIS_LOC:  st_d.len = st_q.len & ~wdata[LOCAL_N-1:0];
                SEL_FAST_CTL: begin
                    st_d.fsel = wdata[SEL_W-1:0];
                    st_d.fen  = wdata[SEL_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pen_mask = st_q.pen;
    assign loc_mask = st_q.len;
    assign fast_en  = st_q.fen;
    assign fast_sel = st_q.fsel;

    // R2: a set write keeps the old ones and adds the written ones
    a_r2_set_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_EN_LO) |=>
            ((st_q.pen[WORD_W-1:0] & $past(st_q.pen[WORD_W-1:0])) == $past(st_q.pen[WORD_W-1:0]))
            && ((st_q.pen[WORD_W-1:0] & $past(wdata)) == $past(wdata)));

    // R3: a clear write leaves none of the written ones set
    a_r3_clear_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_DIS_HI) |=>
            ((st_q.pen[2*WORD_W-1:WORD_W] & $past(wdata)) == '0));

    // R10: writes to unmapped offsets leave all configuration alone
    a_r10_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_NONE) |=> $stable(st_q));

endmodule

// File: rtl/intc_rd_mux.sv
module intc_rd_mux
    import intc_twobank_pkg::*;
#(
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned PERIPH_N = 64,
    parameter int unsigned LOCAL_N  = 8,
    parameter int unsigned SEL_W    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  reg_sel_e            sel,
    input  logic [PERIPH_N-1:0] plvl,
    input  logic [LOCAL_N-1:0]  llvl,
    input  logic [PERIPH_N-1:0] pen_mask,
    input  logic [LOCAL_N-1:0]  loc_mask,
    input  logic                fast_en,
    input  logic [SEL_W-1:0]    fast_sel,
    output logic [WORD_W-1:0]   rd_data
);
    logic [PERIPH_N-1:0] pend;
    logic [LOCAL_N-1:0]  lpend;
    logic [MIRROR_N-1:0] mirror;
    logic [WORD_W-1:0]   rd_d, rd_q;

    assign pend  = plvl & pen_mask;
    assign lpend = llvl & loc_mask;

    for (genvar k = 0; k < MIRROR_N; k++) begin : g_mirror
        assign mirror[k] = pend[mirror_src(k)];
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            case (sel)
                SEL_SUMMARY:  rd_d = WORD_W'({mirror,
                                              |pend[2*WORD_W-1:WORD_W],
                                              |pend[WORD_W-1:0],
                                              lpend});
                SEL_PEND_LO:  rd_d = pend[WORD_W-1:0];
                SEL_PEND_HI:  rd_d = pend[2*WORD_W-1:WORD_W];
                SEL_FAST_CTL: rd_d = WORD_W'({fast_en, fast_sel});
                SEL_EN_LO:    rd_d = pen_mask[WORD_W-1:0];
                SEL_EN_HI:    rd_d = pen_mask[2*WORD_W-1:WORD_W];
                SEL_EN_LOC:   rd_d = WORD_W'(loc_mask);
                SEL_DIS_LO:   rd_d = ~pen_mask[WORD_W-1:0];
                SEL_DIS_HI:   rd_d = ~pen_mask[2*WORD_W-1:WORD_W];
                SEL_DIS_LOC:  rd_d = ~WORD_W'(loc_mask);
                default:      rd_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

    // R5: pending view never shows a line whose level was low
    a_r5_pend_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_PEND_LO) |=> ((rd_data & ~$past(plvl[WORD_W-1:0])) == '0));

    // R10: unmapped reads return zero
    a_r10_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == SEL_NONE) |=> (rd_data == '0));

    // R11: read data holds when no read is accepted
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/intc_out_gen.sv
module intc_out_gen #(
    parameter int unsigned PERIPH_N = 64,
    parameter int unsigned LOCAL_N  = 8,
    parameter int unsigned SEL_W    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIPH_N-1:0] plvl,
    input  logic [LOCAL_N-1:0]  llvl,
    input  logic [PERIPH_N-1:0] pen_mask,
    input  logic [LOCAL_N-1:0]  loc_mask,
    input  logic                fast_en,
    input  logic [SEL_W-1:0]    fast_sel,
    output logic                irq,
    output logic                fast_irq
);
    localparam int unsigned PIDX_W = $clog2(PERIPH_N);
    localparam int unsigned LIDX_W = $clog2(LOCAL_N);
    localparam logic [SEL_W-1:0] LOC_BASE = SEL_W'(PERIPH_N);
    localparam logic [SEL_W-1:0] LOC_END  = SEL_W'(PERIPH_N + LOCAL_N);

    typedef struct packed {
        logic irq;
        logic fast;
    } out_t;

    out_t o_d, o_q;
    logic fast_src;

    always_comb begin
        fast_src = 1'b0;
        if (fast_sel < LOC_BASE)
            fast_src = plvl[fast_sel[PIDX_W-1:0]];
        else if (fast_sel < LOC_END)
            fast_src = llvl[LIDX_W'(fast_sel - LOC_BASE)];
    end

    always_comb begin
        o_d.irq  = (|(plvl & pen_mask)) || (|(llvl & loc_mask));
        o_d.fast = fast_en && fast_src;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign irq      = o_q.irq;
    assign fast_irq = o_q.fast;

    // R7: a request needs some line high one cycle earlier
    a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past((|plvl) || (|llvl)));

    // R8: disabled fast path stays low
    a_r8_fast_off: assert property (@(posedge clk) disable iff (!rst_n)
        !fast_en |=> !fast_irq);

    // R8: selected peripheral line drives the fast output regardless of masks
    a_r8_fast_periph: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_en && fast_sel < LOC_BASE && plvl[fast_sel[PIDX_W-1:0]]) |=> fast_irq);

    // R9: select codes past the last local line route nothing
    a_r9_no_source: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_sel >= LOC_END) |=> !fast_irq);

endmodule

// File: rtl/intc_twobank.sv
module intc_twobank
    import intc_twobank_pkg::*;
#(
    parameter int unsigned ADDR_W   = 12,
    parameter int unsigned WORD_W   = 32,
    parameter int unsigned PERIPH_N = 64,
    parameter int unsigned LOCAL_N  = 8,
    parameter int unsigned SEL_W    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid_i,
    input  logic                req_write_i,
    input  logic [ADDR_W-1:0]   req_addr_i,
    input  logic [WORD_W-1:0]   req_wdata_i,
    input  logic [PERIPH_N-1:0] periph_lvl_i,
    input  logic [LOCAL_N-1:0]  local_lvl_i,
    output logic [WORD_W-1:0]   rd_data_o,
    output logic                irq_o,
    output logic                fast_irq_o
);
    localparam int unsigned OFS_BITS = 8;

    logic                in_window;
    reg_sel_e            sel;
    logic                wr_en, rd_en;
    logic [PERIPH_N-1:0] pen_mask;
    logic [LOCAL_N-1:0]  loc_mask;
    logic                fast_en;
    logic [SEL_W-1:0]    fast_sel;

    assign in_window = (req_addr_i[ADDR_W-1:OFS_BITS] == '0);
    assign sel       = in_window ? decode_ofs(req_addr_i[OFS_BITS-1:0]) : SEL_NONE;
    assign wr_en     = req_valid_i && req_write_i;
    assign rd_en     = req_valid_i && !req_write_i;

    intc_cfg_regs #(
        .WORD_W(WORD_W), .PERIPH_N(PERIPH_N), .LOCAL_N(LOCAL_N), .SEL_W(SEL_W)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(sel), .wdata(req_wdata_i),
        .pen_mask(pen_mask), .loc_mask(loc_mask),
        .fast_en(fast_en), .fast_sel(fast_sel)
    );

    intc_rd_mux #(
        .WORD_W(WORD_W), .PERIPH_N(PERIPH_N), .LOCAL_N(LOCAL_N), .SEL_W(SEL_W)
    ) rd_i (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .sel(sel),
        .plvl(periph_lvl_i), .llvl(local_lvl_i),
        .pen_mask(pen_mask), .loc_mask(loc_mask),
        .fast_en(fast_en), .fast_sel(fast_sel),
        .rd_data(rd_data_o)
    );

    intc_out_gen #(
        .PERIPH_N(PERIPH_N), .LOCAL_N(LOCAL_N), .SEL_W(SEL_W)
    ) out_i (
        .clk(clk), .rst_n(rst_n),
        .plvl(periph_lvl_i), .llvl(local_lvl_i),
        .pen_mask(pen_mask), .loc_mask(loc_mask),
        .fast_en(fast_en), .fast_sel(fast_sel),
        .irq(irq_o), .fast_irq(fast_irq_o)
    );

    // R1: first cycle out of reset has both requests low
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_o && !fast_irq_o && rd_data_o == '0));

endmodule

// File: tb/intc_twobank_tb_top.sv
module intc_twobank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [63:0] plvl = '0;
    logic [7:0]  llvl = '0;
    logic [31:0] rd_data;
    logic        irq, fast_irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    intc_twobank dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_write_i(req_write),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .periph_lvl_i(plvl), .local_lvl_i(llvl),
        .rd_data_o(rd_data), .irq_o(irq), .fast_irq_o(fast_irq)
    );

    // Reference model state
    logic [63:0] m_pen = '0;
    logic [7:0]  m_len = '0;
    logic        m_fen = 1'b0;
    logic [6:0]  m_fsel = '0;
    logic [31:0] m_last_rd = '0;

    function automatic logic [31:0] m_read(input logic [11:0] a,
                                           input logic [63:0] p, input logic [7:0] l);
        logic [63:0] pd;
        logic [31:0] r;
        int mir [11] = '{7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62};
        pd = p & m_pen;
        r  = '0;
        case (a)
            12'h000: begin
                r[7:0] = l & m_len;
                r[8]   = |pd[31:0];
                r[9]   = |pd[63:32];
                for (int i = 0; i < 11; i++) r[10+i] = pd[mir[i]];
            end
            12'h004: r = pd[31:0];
            12'h008: r = pd[63:32];
            12'h00C: r = {24'h0, m_fen, m_fsel};
            12'h010: r = m_pen[31:0];
            12'h014: r = m_pen[63:32];
            12'h018: r = {24'h0, m_len};
            12'h01C: r = ~m_pen[31:0];
            12'h020: r = ~m_pen[63:32];
            12'h024: r = ~{24'h0, m_len};
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic void m_write(input logic [11:0] a, input logic [31:0] w);
        case (a)
            12'h00C: begin m_fsel = w[6:0]; m_fen = w[7]; end
            12'h010: m_pen[31:0]  = m_pen[31:0]  | w;
            12'h014: m_pen[63:32] = m_pen[63:32] | w;
            12'h018: m_len        = m_len | w[7:0];
            12'h01C: m_pen[31:0]  = m_pen[31:0]  & ~w;
            12'h020: m_pen[63:32] = m_pen[63:32] & ~w;
            12'h024: m_len        = m_len & ~w[7:0];
            default: ;
        endcase
    endfunction

    function automatic logic m_fast(input logic [63:0] p, input logic [7:0] l);
        if (!m_fen)        return 1'b0;
        if (m_fsel < 7'd64) return p[m_fsel[5:0]];
        if (m_fsel < 7'd72) return l[m_fsel[2:0]];
        return 1'b0;
    endfunction

    task automatic check(input int tag, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // op: 0 idle, 1 read, 2 write. Called at a falling edge.
    task automatic step(input logic [1:0] op, input logic [11:0] a, input logic [31:0] w,
                        input logic [63:0] p, input logic [7:0] l, input int tag);
        logic exp_irq, exp_fast;
        req_valid = (op != 2'd0);
        req_write = (op == 2'd2);
        req_addr  = a;
        req_wdata = w;
        plvl      = p;
        llvl      = l;
        @(posedge clk);
        @(negedge clk);
        exp_irq  = (|(p & m_pen)) || (|(l & m_len));
        exp_fast = m_fast(p, l);
        if (op == 2'd1) begin
            m_last_rd = m_read(a, p, l);
            check(tag, "read data", rd_data, m_last_rd);
        end else begin
            check(11, "read data held", rd_data, m_last_rd); // R11
        end
        check(7, "irq", {31'h0, irq}, {31'h0, exp_irq});                // R7
        check(8, "fast irq", {31'h0, fast_irq}, {31'h0, exp_fast});     // R8 / R9
        if (op == 2'd2) m_write(a, w);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    typedef struct packed {
        logic [1:0]  op;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [63:0] plvl;
        logic [7:0]  llvl;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 46;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 8'h10, 32'h0,         64'h0,                 8'h00, 4'd1 },  // R1 enables zero
        '{2'd1, 8'h1C, 32'h0,         64'h0,                 8'h00, 4'd1 },  // R1 inverse all ones
        '{2'd1, 8'h24, 32'h0,         64'h0,                 8'h00, 4'd4 },  // R4 local inverse
        '{2'd1, 8'h0C, 32'h0,         64'h0,                 8'h00, 4'd1 },  // R1 fast control zero
        '{2'd2, 8'h10, 32'h0000_0481, 64'h1,                 8'h00, 4'd2 },  // R2 set low bank
        '{2'd0, 8'h00, 32'h0,         64'h1,                 8'h00, 4'd7 },  // R7 irq rises
        '{2'd2, 8'h14, 32'h4020_0001, 64'h0,                 8'h00, 4'd2 },  // R2 set high bank
        '{2'd2, 8'h10, 32'h000C_0200, 64'h0,                 8'h00, 4'd2 },  // R2 OR semantics
        '{2'd1, 8'h10, 32'h0,         64'h0,                 8'h00, 4'd4 },  // R4
        '{2'd1, 8'h14, 32'h0,         64'h0,                 8'h00, 4'd4 },  // R4
        '{2'd1, 8'h1C, 32'h0,         64'h0,                 8'h00, 4'd4 },  // R4
        '{2'd1, 8'h04, 32'h0,         ONES,                  8'h00, 4'd5 },  // R5 low half
        '{2'd1, 8'h08, 32'h0,         ONES,                  8'h00, 4'd5 },  // R5 high half
        '{2'd1, 8'h00, 32'h0,         ONES,                  8'h00, 4'd6 },  // R6 summary
        '{2'd2, 8'h18, 32'hFFFF_FF05, 64'h0,                 8'hFF, 4'd2 },  // R2 local, upper ignored
        '{2'd1, 8'h18, 32'h0,         64'h0,                 8'hFF, 4'd4 },  // R4
        '{2'd1, 8'h24, 32'h0,         64'h0,                 8'hFF, 4'd4 },  // R4
        '{2'd1, 8'h00, 32'h0,         64'h4020_0000_0008_0080, 8'h0F, 4'd6 }, // R6 mixed
        '{2'd2, 8'h1C, 32'h0000_0080, 64'h0,                 8'h00, 4'd3 },  // R3 clear low
        '{2'd1, 8'h04, 32'h0,         ONES,                  8'h00, 4'd3 },  // R3
        '{2'd2, 8'h20, 32'hFFFF_FFFF, ONES,                  8'h00, 4'd3 },  // R3 clear high
        '{2'd1, 8'h14, 32'h0,         ONES,                  8'h00, 4'd3 },  // R3
        '{2'd1, 8'h00, 32'h0,         ONES,                  8'h00, 4'd6 },  // R6 high flag gone
        '{2'd2, 8'h24, 32'h0000_0001, 64'h0,                 8'h00, 4'd3 },  // R3 clear local
        '{2'd1, 8'h18, 32'h0,         64'h0,                 8'h00, 4'd3 },  // R3
        '{2'd0, 8'h00, 32'h0,         64'h0,                 8'h00, 4'd7 },  // R7 low
        '{2'd0, 8'h00, 32'h0,         64'h0,                 8'h04, 4'd7 },  // R7 local source
        '{2'd2, 8'h0C, 32'h0000_0085, 64'h20,                8'h00, 4'd8 },  // R8 unmasked line 5
        '{2'd0, 8'h00, 32'h0,         64'h20,                8'h00, 4'd8 },  // R8
        '{2'd0, 8'h00, 32'h0,         64'h0,                 8'h00, 4'd8 },  // R8 follows level
        '{2'd1, 8'h0C, 32'h0,         64'h0,                 8'h00, 4'd8 },  // R8 readback
        '{2'd2, 8'h0C, 32'h0000_00C3, 64'h0,                 8'h08, 4'd8 },  // R8 local 3
        '{2'd0, 8'h00, 32'h0,         64'h0,                 8'h08, 4'd8 },  // R8
        '{2'd0, 8'h00, 32'h0,         64'h0,                 8'h00, 4'd8 },  // R8
        '{2'd2, 8'h0C, 32'h0000_00C8, ONES,                  8'hFF, 4'd9 },  // R9 select 72
        '{2'd0, 8'h00, 32'h0,         ONES,                  8'hFF, 4'd9 },  // R9
        '{2'd2, 8'h0C, 32'h0000_00FF, ONES,                  8'hFF, 4'd9 },  // R9 select 127
        '{2'd0, 8'h00, 32'h0,         ONES,                  8'hFF, 4'd9 },  // R9
        '{2'd2, 8'h0C, 32'h0000_0045, ONES,                  8'hFF, 4'd8 },  // R8 disabled
        '{2'd0, 8'h00, 32'h0,         ONES,                  8'hFF, 4'd8 },  // R8
        '{2'd2, 8'h28, 32'hFFFF_FFFF, 64'h0,                 8'h00, 4'd10},  // R10 unmapped write
        '{2'd1, 8'h28, 32'h0,         64'h0,                 8'h00, 4'd10},  // R10
        '{2'd2, 8'h11, 32'hFFFF_FFFF, 64'h0,                 8'h00, 4'd10},  // R10 misaligned
        '{2'd1, 8'h11, 32'h0,         64'h0,                 8'h00, 4'd10},  // R10
        '{2'd1, 8'h10, 32'h0,         64'h0,                 8'h00, 4'd10},  // R10 mask intact
        '{2'd1, 8'h3C, 32'h0,         64'h0,                 8'h00, 4'd10}   // R10
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check(1, "irq after reset", {31'h0, irq}, 32'h0);
        check(1, "fast after reset", {31'h0, fast_irq}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(1, "read data after reset", rd_data, 32'h0);

        for (int i = 0; i < NV; i++)
            step(VEC[i].op, {4'h0, VEC[i].addr}, VEC[i].wdata, VEC[i].plvl, VEC[i].llvl,
                 int'(VEC[i].tag));

        // R10: address bits above the window reject an access aliasing 0x10
        step(2'd2, 12'h110, 32'hFFFF_FFFF, 64'h0, 8'h00, 10);
        step(2'd1, 12'h010, 32'h0, 64'h0, 8'h00, 10);
        step(2'd1, 12'h110, 32'h0, 64'h0, 8'h00, 10);

        // R1: a second reset with masks and fast path set
        step(2'd2, 12'h018, 32'h0000_00FF, ONES, 8'hFF, 1);
        step(2'd2, 12'h00C, 32'h0000_0081, ONES, 8'hFF, 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_pen = '0; m_len = '0; m_fen = 1'b0; m_fsel = '0; m_last_rd = '0;
        check(1, "read data cleared", rd_data, 32'h0);
        step(2'd0, 12'h000, 32'h0, ONES, 8'hFF, 1);
        step(2'd1, 12'h014, 32'h0, ONES, 8'hFF, 1);
        step(2'd1, 12'h018, 32'h0, ONES, 8'hFF, 1);
        step(2'd1, 12'h00C, 32'h0, ONES, 8'hFF, 1);
        step(2'd1, 12'h020, 32'h0, ONES, 8'hFF, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule